// File: doc/BRIEF.md
# Write Status Polling Responder

This block shapes the byte that a self-timed nonvolatile memory returns on a read while its internal program cycle runs. It does not time the program cycle and does not hold the array. The program timer supplies a busy level and the array supplies the stored byte. The block records the last byte loaded before programming starts. On each read it returns either a status word or the true stored byte.

While busy is high, each read returns a status word. The top bit of that word is the inverse of the top bit of the last loaded byte. The next bit flips from one busy read to the next. All lower bits are zero. Software can poll either bit to find out when programming has finished. Once busy falls, reads return the array data unchanged, and the flipping bit holds still. The same behaviour covers a single-byte write and a multi-byte page load, because only the final load counts.

A read is the rising edge of `rd_strobe`. The returned byte is registered on that edge and holds until the next read.

Top module: `status_poll_resp`

## Requirements
- R1: After reset, `rd_data` is all zeros.
- R2: A read while `busy` is high returns bit 7 equal to the inverse of bit 7 of the last byte loaded while `busy` was low.
- R3: A read while `busy` is high returns bits 5 down to 0 as zero.
- R4: Bit 6 of each read taken while `busy` is high differs from bit 6 of the previous read taken while `busy` was high.
- R5: A read while `busy` is low returns all eight bits of `arr_data` as they were at the strobe's rising edge.
- R6: `rd_data` changes only in the cycle after a rising edge of `rd_strobe`. A strobe held high or held low, or a change of `arr_data`, leaves it unchanged.
- R7: A load (`wr_strobe` high) while `busy` is high has no effect on the recorded byte.
- R8: When several bytes are loaded before `busy` rises, the status word is built from the final one.
- R9: Reads while `busy` is low do not advance the flipping bit. The first busy read after idle reads therefore still differs in bit 6 from the last busy read before them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| busy | input | 1 | High while the program cycle runs |
| wr_strobe | input | 1 | One-cycle byte load pulse |
| wr_data | input | 8 | Byte being loaded |
| rd_strobe | input | 1 | Read request; its rising edge starts a read |
| arr_data | input | 8 | Stored byte from the array |
| rd_data | output | 8 | Byte returned to the bus |

## Verification
The assertions assume that `busy`, `wr_strobe` and `arr_data` are synchronous to `clk` and are stable around each rising clock edge. They also assume that `busy` does not change in the same cycle as a load that the design is expected to record. The stimulus changes every input on the falling clock edge only. It puts at least one clock cycle between a load, a change of `busy` and the next read. Each read is a strobe held high for one cycle and then dropped for one cycle, except in the test that deliberately holds the strobe high.

// File: rtl/poll_pkg.sv
package poll_pkg;
    localparam int unsigned POLL_DATA_W = 8;

    typedef enum logic [1:0] {
        SRC_HOLD   = 2'd0,
        SRC_ARRAY  = 2'd1,
        SRC_STATUS = 2'd2
    } rd_src_e;
endpackage

// File: rtl/poll_strobe_edge.sv
module poll_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    output logic rise
);
    typedef struct packed {
        logic prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = strobe;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise = strobe & ~st_q.prev;
endmodule

// File: rtl/poll_last_byte.sv
module poll_last_byte #(
    parameter int unsigned DATA_W = poll_pkg::POLL_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    output logic              last_msb
);
    typedef struct packed {
        logic [DATA_W-1:0] byte_v;
    } last_st_t;

    last_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // Loads arriving during a program cycle are not recorded.
        if (load && !busy) st_d.byte_v = load_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign last_msb = st_q.byte_v[DATA_W-1];
endmodule

// File: rtl/poll_toggle.sv
module poll_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic advance,
    output logic tog
);
    typedef struct packed {
        logic bit_v;
    } tog_st_t;

    tog_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (advance) st_d.bit_v = ~st_q.bit_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tog = st_q.bit_v;
endmodule

// File: rtl/poll_out_sel.sv
module poll_out_sel #(
    parameter int unsigned DATA_W = poll_pkg::POLL_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_rise,
    input  logic              busy,
    input  logic              last_msb,
    input  logic              tog,
    input  logic [DATA_W-1:0] arr_data,
    output logic [DATA_W-1:0] rd_data
);
    import poll_pkg::*;

    localparam int unsigned POLL_BIT = DATA_W - 1;
    localparam int unsigned TOG_BIT  = DATA_W - 2;

    typedef struct packed {
        logic [DATA_W-1:0] word;
    } out_st_t;

    out_st_t           st_d, st_q;
    rd_src_e           src;
    logic [DATA_W-1:0] status_word;

    always_comb begin
        status_word           = '0;
        status_word[POLL_BIT] = ~last_msb;
        status_word[TOG_BIT]  = tog;
    end

    always_comb begin
        if (!rd_rise)  src = SRC_HOLD;
        else if (busy) src = SRC_STATUS;
        else           src = SRC_ARRAY;
    end

    always_comb begin
        st_d = st_q;
        case (src)
            SRC_ARRAY:  st_d.word = arr_data;
            SRC_STATUS: st_d.word = status_word;
            default:    st_d.word = st_q.word;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = st_q.word;
endmodule

// File: rtl/status_poll_resp.sv
module status_poll_resp #(
    parameter int unsigned DATA_W = poll_pkg::POLL_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              wr_strobe,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_strobe,
    input  logic [DATA_W-1:0] arr_data,
    output logic [DATA_W-1:0] rd_data
);
    logic rd_rise;
    logic last_msb;
    logic tog;
    logic tog_adv;

    poll_strobe_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (rd_strobe),
        .rise   (rd_rise)
    );

    poll_last_byte #(.DATA_W(DATA_W)) u_last (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy      (busy),
        .load      (wr_strobe),
        .load_data (wr_data),
        .last_msb  (last_msb)
    );

    assign tog_adv = rd_rise & busy;

    poll_toggle u_tog (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (tog_adv),
        .tog     (tog)
    );

    poll_out_sel #(.DATA_W(DATA_W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_rise  (rd_rise),
        .busy     (busy),
        .last_msb (last_msb),
        .tog      (tog),
        .arr_data (arr_data),
        .rd_data  (rd_data)
    );
endmodule

// File: rtl/status_poll_chk.sv
module status_poll_chk #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              wr_strobe,
    input logic [DATA_W-1:0] wr_data,
    input logic              rd_strobe,
    input logic [DATA_W-1:0] arr_data,
    input logic [DATA_W-1:0] rd_data
);
    localparam int unsigned POLL_BIT = DATA_W - 1;
    localparam int unsigned TOG_BIT  = DATA_W - 2;

    logic seen_prev_q;
    logic last_top_q;
    logic busy_rd_q;
    logic have_b6_q;
    logic b6_q;
    logic rise;

    assign rise = rd_strobe & ~seen_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_prev_q <= 1'b0;
            last_top_q  <= 1'b0;
            busy_rd_q   <= 1'b0;
            have_b6_q   <= 1'b0;
            b6_q        <= 1'b0;
        end else begin
            seen_prev_q <= rd_strobe;
            busy_rd_q   <= rise & busy;
            if (wr_strobe && !busy) last_top_q <= wr_data[POLL_BIT];
            if (busy_rd_q) begin
                have_b6_q <= 1'b1;
                b6_q      <= rd_data[TOG_BIT];
            end
        end
    end

    assert_rd_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (rd_data == '0));

    assert_poll_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && busy) |=> (rd_data[POLL_BIT] != $past(last_top_q)));

    assert_low_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && busy) |=> (rd_data[TOG_BIT-1:0] == '0));

    assert_toggle_alt_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_rd_q && have_b6_q) |-> (rd_data[TOG_BIT] != b6_q));

    assert_idle_true_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && !busy) |=> (rd_data == $past(arr_data)));

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rise |=> $stable(rd_data));
endmodule

bind status_poll_resp status_poll_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .wr_strobe (wr_strobe),
    .wr_data   (wr_data),
    .rd_strobe (rd_strobe),
    .arr_data  (arr_data),
    .rd_data   (rd_data)
);

// File: tb/tb_status_poll_resp.sv
module tb_status_poll_resp;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       busy = 1'b0;
    logic       wr_strobe = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_strobe = 1'b0;
    logic [7:0] arr_data = 8'h00;
    logic [7:0] rd_data;

    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;
    bit  have_b6 = 1'b0;
    bit  prev_b6 = 1'b0;
    int  cycles = 0;

    always #4 clk = ~clk;

    status_poll_resp dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy      (busy),
        .wr_strobe (wr_strobe),
        .wr_data   (wr_data),
        .rd_strobe (rd_strobe),
        .arr_data  (arr_data),
        .rd_data   (rd_data)
    );

    // Vector: op[17:16] (0 load, 1 read, 2 set busy to din[0]), din[15:8], exp[7:0]
    localparam logic [17:0] VEC [18] = '{
        {2'd0, 8'h3C, 8'h00},  // load 0x3C
        {2'd1, 8'h5A, 8'h5A},  // idle read, R5
        {2'd2, 8'h01, 8'h00},  // busy up
        {2'd1, 8'hFF, 8'h80},  // R2: ~0 -> bit7 = 1, R3 low bits zero
        {2'd1, 8'h00, 8'h80},  // R4 alternation
        {2'd0, 8'h80, 8'h00},  // R7: load while busy is dropped
        {2'd1, 8'h7F, 8'h80},  // R7 recorded byte still 0x3C
        {2'd2, 8'h00, 8'h00},  // busy down
        {2'd1, 8'hC3, 8'hC3},  // R5
        {2'd1, 8'h24, 8'h24},  // R5, R9 idle read does not advance toggle
        {2'd0, 8'h11, 8'h00},  // R8 page: first byte
        {2'd0, 8'h92, 8'h00},  // R8 page: final byte
        {2'd2, 8'h01, 8'h00},  // busy up
        {2'd1, 8'hAA, 8'h00},  // R8: ~1 -> bit7 = 0, R9 continuity
        {2'd1, 8'h55, 8'h00},  // R4
        {2'd1, 8'h01, 8'h00},  // R4
        {2'd2, 8'h00, 8'h00},  // busy down
        {2'd1, 8'hFF, 8'hFF}   // R5 all ones
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic do_load(input logic [7:0] d);
        wr_strobe = 1'b1;
        wr_data   = d;
        @(negedge clk);
        wr_strobe = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_read(input logic [7:0] a, output logic [7:0] r);
        arr_data  = a;
        rd_strobe = 1'b1;
        @(negedge clk);
        r = rd_data;
        rd_strobe = 1'b0;
        @(negedge clk);
    endtask

    task automatic note_busy_read(input logic [7:0] r);
        if (have_b6) check("R4", {7'd0, r[6]}, {7'd0, ~prev_b6});
        have_b6 = 1'b1;
        prev_b6 = r[6];
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                total++;
                bad++;
                $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cycles);
                finish_run();
            end
        end
    end

    initial begin
        logic [7:0] r;
        logic [7:0] held;
        logic       t_before;
        repeat (3) @(negedge clk);
        check("R1", rd_data, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", rd_data, 8'h00);

        for (int i = 0; i < 18; i++) begin
            logic [1:0] op;
            logic [7:0] din;
            logic [7:0] exp;
            {op, din, exp} = VEC[i];
            case (op)
                2'd0: do_load(din);
                2'd2: begin
                    busy = din[0];
                    @(negedge clk);
                end
                default: begin
                    do_read(din, r);
                    if (busy) begin
                        check("R2/R3/R7/R8 status", r & 8'hBF, exp);
                        note_busy_read(r);
                    end else begin
                        check("R5 idle data", r, exp);
                    end
                end
            endcase
        end

        // R6: strobe held high across several cycles with changing array data
        arr_data  = 8'h66;
        rd_strobe = 1'b1;
        @(negedge clk);
        held = rd_data;
        check("R6 read edge", held, 8'h66);
        arr_data = 8'h99;
        repeat (3) @(negedge clk);
        check("R6 held high", rd_data, held);
        rd_strobe = 1'b0;
        arr_data  = 8'h11;
        repeat (3) @(negedge clk);
        check("R6 held low", rd_data, held);

        // R9: idle reads between busy windows do not move bit 6
        do_load(8'h00);
        busy = 1'b1;
        @(negedge clk);
        do_read(8'h00, r);
        check("R2 after load 0x00", r & 8'hBF, 8'h80);
        note_busy_read(r);
        t_before = r[6];
        busy = 1'b0;
        @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            do_read(8'h40 | 8'(k), r);
            check("R5 idle between", r, 8'h40 | 8'(k));
        end
        busy = 1'b1;
        @(negedge clk);
        do_read(8'h00, r);
        check("R9 bit6 continuity", {7'd0, r[6]}, {7'd0, ~t_before});
        note_busy_read(r);
        check("R3 low bits", r & 8'h3F, 8'h00);

        // R7: several loads while busy leave the status word unchanged
        do_load(8'hFF);
        do_load(8'h80);
        do_read(8'h00, r);
        check("R7 busy loads dropped", r & 8'hBF, 8'h80);
        note_busy_read(r);
        busy = 1'b0;
        @(negedge clk);

        finish_run();
    end
endmodule